// File: doc/BRIEF.md
# Pipeline Stall Cycle Accounting Unit

This unit keeps the cycle books for an in-order core that issues instructions one at a time or as a parallel pair. Each cycle it may accept one instruction record: a base cycle count, an instruction class, up to two source register numbers with their valid flags, a load destination register, a branch-taken flag, and flags that mark the first and the last instruction of an issue group. From these records it keeps a running total of cycles, the load-stall and branch-stall cycles, and counts of taken and not-taken branches.

A 16-entry register scoreboard records which registers a load has just written. A later instruction that reads one of those registers is charged a fixed load-use penalty for each source that hits. A taken branch adds a fixed redirect penalty. The two halves of a parallel pair overlap, so only the larger of their two costs is added to the total. The stall counters still record every stall that either half incurs.

Top module: `cycle_stall_acct`

## Requirements
- R1: Each source register whose valid flag is high and whose bit is set in the active load mask adds 2 cycles to the load-stall counter and to the instruction's cost. Two hitting sources add 4 cycles, even when both name the same register. A source whose valid flag is low never stalls.
- R2: An instruction of class branch (class code 3) with taken_i high adds 2 cycles to the branch-stall counter and to its cost. A not-taken branch adds nothing. taken_i has no effect on any other class.
- R3: A branch-class instruction increments the taken counter when taken_i is high and the untaken counter otherwise. Instructions of other classes leave both counters unchanged.
- R4: A load (class code 4) sets the bit of its destination register in the load mask. After every instruction the mask becomes the active mask checked by the next instruction. A first-flagged instruction starts the mask from empty, so a load stalls only the next issue group. Destination registers of non-load classes are ignored.
- R5: The cost of an instruction is its base cycles plus its load-stall and branch-stall cycles. A single-issue instruction (first and last both high) adds its whole cost to the total.
- R6: For a pair, the first instruction (first high, last low) adds nothing to the total and its cost is held. At the last instruction the larger of the held cost and its own cost is added to the total. The second instruction sees loads issued by the first.
- R7: The load-stall and branch-stall counters accumulate the stalls of every instruction, whatever its position in a pair.
- R8: Every counter saturates at its full-scale value and never wraps.
- R9: Reset clears every counter and the load mask. While valid_i is low, no counter and no mask bit changes, whatever the other inputs are. A record accepted at a clock edge is reflected in the outputs right after that edge.
- R10: Class codes are 0 execute, 1 compare, 2 multiply-accumulate, 3 branch, 4 load and 5 store. Every class checks its sources for load stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction record strobe |
| class_i | input | 3 | Instruction class code |
| base_cyc_i | input | BASE_W | Base cycle count of the instruction |
| src_a_i | input | log2(NREG) | First source register number |
| src_a_vld_i | input | 1 | First source is read |
| src_b_i | input | log2(NREG) | Second source register number |
| src_b_vld_i | input | 1 | Second source is read |
| dst_i | input | log2(NREG) | Load destination register |
| taken_i | input | 1 | Branch taken |
| first_i | input | 1 | First instruction of an issue group |
| last_i | input | 1 | Last instruction of an issue group |
| total_o | output | CNT_W | Total cycle count |
| load_stall_o | output | CNT_W | Accumulated load-stall cycles |
| br_stall_o | output | CNT_W | Accumulated branch-stall cycles |
| taken_cnt_o | output | CNT_W | Taken branch count |
| untaken_cnt_o | output | CNT_W | Not-taken branch count |

## Verification
The bench builds the unit with CNT_W=8 and BASE_W=4 and keeps NREG at 16. The 8-bit counters bring saturation of the total within a few dozen instructions, so the clamp at 255 can be exercised directly. With the 4-bit base field, the widest cost of 21 cycles still fits each counter's increment path. The full 16-register scoreboard stays in place, so register numbers anywhere in the file can be used to test load-use hits, same-register double hits and the clearing of the mask at each new issue group.

// File: rtl/stall_acct_pkg.sv
package stall_acct_pkg;
  typedef enum logic [2:0] {
    CLS_EXEC   = 3'd0,
    CLS_CMP    = 3'd1,
    CLS_MAC    = 3'd2,
    CLS_BRANCH = 3'd3,
    CLS_LOAD   = 3'd4,
    CLS_STORE  = 3'd5
  } insn_class_e;

  localparam int unsigned LOAD_PENALTY   = 2;
  localparam int unsigned BRANCH_PENALTY = 2;
  localparam int unsigned NUM_CNT        = 5;
endpackage

// File: rtl/sa_scoreboard.sv
module sa_scoreboard #(
  parameter int unsigned NREG = 16,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          first_i,
  input  logic          is_load_i,
  input  logic [RW-1:0] src_a_i,
  input  logic          src_a_vld_i,
  input  logic [RW-1:0] src_b_i,
  input  logic          src_b_vld_i,
  input  logic [RW-1:0] dst_i,
  output logic [1:0]    hit_o
);
  // one register serves as both pending and active mask: it is read before
  // the clear-at-first and the load set are applied
  logic [NREG-1:0] mask_q;
  logic [NREG-1:0] mask_d;
  logic [NREG-1:0] set_bit;

  always_comb begin
    set_bit = '0;
    if (is_load_i) set_bit[dst_i] = 1'b1;
    mask_d = (first_i ? '0 : mask_q) | set_bit;
    hit_o[0] = src_a_vld_i && mask_q[src_a_i];
    hit_o[1] = src_b_vld_i && mask_q[src_b_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (valid_i) mask_q <= mask_d;
  end
endmodule

// File: rtl/sa_pair_merge.sv
module sa_pair_merge #(
  parameter int unsigned CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          first_i,
  input  logic          last_i,
  input  logic [CW-1:0] cost_i,
  output logic          add_en_o,
  output logic [CW-1:0] add_amt_o
);
  logic [CW-1:0] held_q;
  logic [CW-1:0] held_eff;

  always_comb begin
    held_eff  = first_i ? '0 : held_q;
    add_en_o  = valid_i && last_i;
    add_amt_o = (cost_i > held_eff) ? cost_i : held_eff;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  held_q <= '0;
    else if (valid_i && !last_i)  held_q <= cost_i;
  end
endmodule

// File: rtl/sa_sat_cnt.sv
module sa_sat_cnt #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [IW-1:0] inc_i,
  output logic [W-1:0]  cnt_o
);
  logic [W:0] sum;

  always_comb sum = {1'b0, cnt_o} + {{(W + 1 - IW){1'b0}}, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (en_i) cnt_o <= sum[W] ? {W{1'b1}} : sum[W-1:0];
  end
endmodule

// File: rtl/cycle_stall_acct.sv
module cycle_stall_acct
  import stall_acct_pkg::*;
#(
  parameter int unsigned NREG   = 16,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned BASE_W = 8,
  localparam int unsigned RW    = $clog2(NREG),
  localparam int unsigned CW    = BASE_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        class_i,
  input  logic [BASE_W-1:0] base_cyc_i,
  input  logic [RW-1:0]     src_a_i,
  input  logic              src_a_vld_i,
  input  logic [RW-1:0]     src_b_i,
  input  logic              src_b_vld_i,
  input  logic [RW-1:0]     dst_i,
  input  logic              taken_i,
  input  logic              first_i,
  input  logic              last_i,
  output logic [CNT_W-1:0]  total_o,
  output logic [CNT_W-1:0]  load_stall_o,
  output logic [CNT_W-1:0]  br_stall_o,
  output logic [CNT_W-1:0]  taken_cnt_o,
  output logic [CNT_W-1:0]  untaken_cnt_o
);
  logic [1:0]    hit;
  logic          is_br, is_load;
  logic [CW-1:0] ld_stall, br_stall, cost;
  logic          tot_en;
  logic [CW-1:0] tot_amt;

  logic [NUM_CNT-1:0]         cnt_en;
  logic [NUM_CNT-1:0][CW-1:0] cnt_inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;

  always_comb begin
    is_br   = (class_i == CLS_BRANCH);
    is_load = (class_i == CLS_LOAD);
    ld_stall = CW'(LOAD_PENALTY) * CW'(hit[0]) + CW'(LOAD_PENALTY) * CW'(hit[1]);
    br_stall = (is_br && taken_i) ? CW'(BRANCH_PENALTY) : '0;
    cost     = CW'(base_cyc_i) + ld_stall + br_stall;
  end

  sa_scoreboard #(.NREG(NREG)) u_sb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .first_i     (first_i),
    .is_load_i   (is_load),
    .src_a_i     (src_a_i),
    .src_a_vld_i (src_a_vld_i),
    .src_b_i     (src_b_i),
    .src_b_vld_i (src_b_vld_i),
    .dst_i       (dst_i),
    .hit_o       (hit)
  );

  sa_pair_merge #(.CW(CW)) u_pair (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .first_i   (first_i),
    .last_i    (last_i),
    .cost_i    (cost),
    .add_en_o  (tot_en),
    .add_amt_o (tot_amt)
  );

  // counter order: total, load stall, branch stall, taken, untaken
  always_comb begin
    cnt_en[0]  = tot_en;
    cnt_inc[0] = tot_amt;
    cnt_en[1]  = valid_i && (hit != 2'b00);
    cnt_inc[1] = ld_stall;
    cnt_en[2]  = valid_i && is_br && taken_i;
    cnt_inc[2] = br_stall;
    cnt_en[3]  = valid_i && is_br && taken_i;
    cnt_inc[3] = CW'(1);
    cnt_en[4]  = valid_i && is_br && !taken_i;
    cnt_inc[4] = CW'(1);
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    sa_sat_cnt #(.W(CNT_W), .IW(CW)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (cnt_en[g]),
      .inc_i  (cnt_inc[g]),
      .cnt_o  (cnt_val[g])
    );
  end

  assign total_o       = cnt_val[0];
  assign load_stall_o  = cnt_val[1];
  assign br_stall_o    = cnt_val[2];
  assign taken_cnt_o   = cnt_val[3];
  assign untaken_cnt_o = cnt_val[4];
endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [2:0]       class_i,
  input logic             taken_i,
  input logic             last_i,
  input logic             src_a_vld_i,
  input logic             src_b_vld_i,
  input logic [CNT_W-1:0] total_o,
  input logic [CNT_W-1:0] load_stall_o,
  input logic [CNT_W-1:0] br_stall_o,
  input logic [CNT_W-1:0] taken_cnt_o,
  input logic [CNT_W-1:0] untaken_cnt_o
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (total_o >= $past(total_o)) && (load_stall_o >= $past(load_stall_o)));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(total_o) && $stable(load_stall_o) && $stable(br_stall_o)
                 && $stable(taken_cnt_o) && $stable(untaken_cnt_o));

  assert_taken_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && class_i == 3'd3 && taken_i && taken_cnt_o != FULL
    |=> taken_cnt_o == $past(taken_cnt_o) + 1'b1);

  assert_nonbr_counts_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && class_i != 3'd3 |=> $stable(taken_cnt_o) && $stable(untaken_cnt_o));

  assert_nonbr_nostall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && class_i != 3'd3 |=> $stable(br_stall_o));

  assert_nosrc_nostall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !src_a_vld_i && !src_b_vld_i |=> $stable(load_stall_o));

  assert_first_half_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !last_i |=> $stable(total_o));
endmodule

bind cycle_stall_acct sa_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .class_i       (class_i),
  .taken_i       (taken_i),
  .last_i        (last_i),
  .src_a_vld_i   (src_a_vld_i),
  .src_b_vld_i   (src_b_vld_i),
  .total_o       (total_o),
  .load_stall_o  (load_stall_o),
  .br_stall_o    (br_stall_o),
  .taken_cnt_o   (taken_cnt_o),
  .untaken_cnt_o (untaken_cnt_o)
);

// File: tb/sim_cycle_stall_acct.sv
`timescale 1ns/1ps
module sim_cycle_stall_acct;
  localparam int unsigned NREG = 16, CNT_W = 8, BASE_W = 4, RW = 4;
  localparam int FULL = 255;

  logic clk = 0, rst_ni = 0;
  logic valid_i = 0, src_a_vld_i = 0, src_b_vld_i = 0, taken_i = 0, first_i = 0, last_i = 0;
  logic [2:0] class_i = 0;
  logic [BASE_W-1:0] base_cyc_i = 0;
  logic [RW-1:0] src_a_i = 0, src_b_i = 0, dst_i = 0;
  logic [CNT_W-1:0] total_o, load_stall_o, br_stall_o, taken_cnt_o, untaken_cnt_o;

  always #5 clk = ~clk;

  cycle_stall_acct #(.NREG(NREG), .CNT_W(CNT_W), .BASE_W(BASE_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .class_i(class_i),
    .base_cyc_i(base_cyc_i), .src_a_i(src_a_i), .src_a_vld_i(src_a_vld_i),
    .src_b_i(src_b_i), .src_b_vld_i(src_b_vld_i), .dst_i(dst_i), .taken_i(taken_i),
    .first_i(first_i), .last_i(last_i), .total_o(total_o), .load_stall_o(load_stall_o),
    .br_stall_o(br_stall_o), .taken_cnt_o(taken_cnt_o), .untaken_cnt_o(untaken_cnt_o));

  typedef struct {
    int tot, ls, bs, tk, ut;
    string tag;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  // reference state
  int m_tot = 0, m_ls = 0, m_bs = 0, m_tk = 0, m_ut = 0, m_held = 0;
  bit [NREG-1:0] m_mask = '0;

  function automatic int sat(int v);
    return (v > FULL) ? FULL : v;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(string tag, int tot, int ls, int bs, int tk, int ut);
    chk({tag, " R5 total"}, int'(total_o), tot);
    chk({tag, " R1 load_stall"}, int'(load_stall_o), ls);
    chk({tag, " R2 br_stall"}, int'(br_stall_o), bs);
    chk({tag, " R3 taken"}, int'(taken_cnt_o), tk);
    chk({tag, " R3 untaken"}, int'(untaken_cnt_o), ut);
  endtask

  // driver: apply one record and push the expected counter state
  task automatic issue(string tag, int cls, int base, int sa, bit sav, int sb, bit sbv,
                       int dst, bit tk, bit fst, bit lst);
    int ls, bs, cost, h;
    exp_t e;
    @(negedge clk);
    valid_i = 1; class_i = 3'(cls); base_cyc_i = BASE_W'(base);
    src_a_i = RW'(sa); src_a_vld_i = sav; src_b_i = RW'(sb); src_b_vld_i = sbv;
    dst_i = RW'(dst); taken_i = tk; first_i = fst; last_i = lst;
    ls = (sav && m_mask[sa] ? 2 : 0) + (sbv && m_mask[sb] ? 2 : 0);
    bs = (cls == 3 && tk) ? 2 : 0;
    cost = base + ls + bs;
    if (fst) m_mask = '0;
    if (cls == 4) m_mask[dst] = 1'b1;
    if (!lst) m_held = cost;
    else begin
      h = fst ? 0 : m_held;
      m_tot = sat(m_tot + ((cost > h) ? cost : h));
    end
    m_ls = sat(m_ls + ls);
    m_bs = sat(m_bs + bs);
    if (cls == 3) begin
      if (tk) m_tk = sat(m_tk + 1); else m_ut = sat(m_ut + 1);
    end
    e.tot = m_tot; e.ls = m_ls; e.bs = m_bs; e.tk = m_tk; e.ut = m_ut; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 0;
    end
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      if (valid_i) begin
        @(negedge clk);
        if (q.size() == 0) chk("R9 unexpected record", 1, 0);
        else begin
          e = q.pop_front();
          chk_all(e.tag, e.tot, e.ls, e.bs, e.tk, e.ut);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R9 reset", 0, 0, 0, 0, 0);
    rst_ni = 1;
    idle(1);
    // R5 single issue
    issue("R5 single exec", 0, 3, 0, 0, 0, 0, 0, 0, 1, 1);
    // R4/R1 load-use then cleared mask
    issue("R4 load r5", 4, 1, 0, 0, 0, 0, 5, 0, 1, 1);
    issue("R1 use r5", 0, 1, 5, 1, 0, 0, 0, 0, 1, 1);
    issue("R4 mask cleared", 1, 1, 5, 1, 0, 0, 0, 0, 1, 1);
    // R1 double hit same register
    issue("R4 load r7", 4, 2, 0, 0, 0, 0, 7, 0, 1, 1);
    issue("R1 double hit", 2, 1, 7, 1, 7, 1, 0, 0, 1, 1);
    // R1 invalid source does not stall
    issue("R4 load r2", 4, 1, 0, 0, 0, 0, 2, 0, 1, 1);
    issue("R1 invalid src", 5, 1, 2, 0, 2, 0, 0, 0, 1, 1);
    // R4 non-load destination ignored
    issue("R4 exec dst r3", 0, 1, 0, 0, 0, 0, 3, 0, 1, 1);
    issue("R4 no stall r3", 5, 1, 3, 1, 3, 1, 0, 0, 1, 1);
    // R2/R3 branches
    issue("R2 taken", 3, 1, 0, 0, 0, 0, 0, 1, 1, 1);
    issue("R3 not taken", 3, 1, 0, 0, 0, 0, 0, 0, 1, 1);
    issue("R2 exec taken ignored", 0, 1, 0, 0, 0, 0, 0, 1, 1, 1);
    // R10 branch also checks sources
    issue("R10 load r9", 4, 1, 0, 0, 0, 0, 9, 0, 1, 1);
    issue("R10 branch src r9", 3, 1, 9, 1, 0, 0, 0, 1, 1, 1);
    // R6 pair max
    issue("R6 pair first", 0, 2, 0, 0, 0, 0, 0, 0, 1, 0);
    issue("R6 pair last", 0, 5, 0, 0, 0, 0, 0, 0, 0, 1);
    // R6/R7 second sees first's load, stall still counted
    issue("R6 pair load r4", 4, 3, 0, 0, 0, 0, 4, 0, 1, 0);
    issue("R7 pair use r4", 0, 0, 4, 1, 0, 0, 0, 0, 0, 1);
    // R7 first-half stall with larger first cost
    issue("R7 load r1", 4, 1, 0, 0, 0, 0, 1, 0, 1, 1);
    issue("R7 first uses r1", 3, 6, 1, 1, 0, 0, 0, 1, 1, 0);
    issue("R6 second small", 0, 1, 0, 0, 0, 0, 0, 0, 0, 1);
    // R9 idle with garbage inputs
    @(negedge clk);
    valid_i = 0; class_i = 3'd3; taken_i = 1; src_a_i = 4'd1; src_a_vld_i = 1;
    first_i = 1; last_i = 1; base_cyc_i = 4'd9;
    repeat (3) @(negedge clk);
    chk_all("R9 idle", m_tot, m_ls, m_bs, m_tk, m_ut);
    issue("R9 mask kept after idle", 0, 1, 1, 1, 0, 0, 0, 0, 1, 1);
    // R8 saturation
    for (int i = 0; i < 20; i++) issue("R8 fill", 0, 15, 0, 0, 0, 0, 0, 0, 1, 1);
    idle(2);
    chk("R8 total saturated", int'(total_o), FULL);
    chk("R8 queue drained", q.size(), 0);
    finish_run();
  end
endmodule